// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel Sequencer

This block is the control engine of one DMA channel. Software places a linked list of fixed 32-byte descriptors in memory, loads the address of the first one into the chain pointer register, sets the channel enable, and writes the doorbell register. The sequencer then reads the eight words of the descriptor over a word-wide memory request port. If the descriptor is valid, it passes the source address, the destination address and the byte count to an external data mover and waits for the mover to finish.

When the mover is done, the sequencer carries out the write-back that the descriptor asks for. It raises a sticky interrupt-pending flag and moves on to the descriptor named by the link word. A descriptor whose valid bit is clear stops the chain and sets the halted status. A doorbell that was rung while the channel was busy is remembered, so after a halt the sequencer reads that same descriptor again straight away.

Top module: `dmaseq_channel`

## Requirements
- R1: After reset, the status word reads 0, the interrupt line is low, and no memory request and no mover start is active.
- R2: Writing any value to the doorbell register (reg_addr 3) sets status bit 2 on the next cycle. If the channel is enabled, the descriptor fetch begins one cycle later, and status bit 2 clears when that fetch begins.
- R3: A fetch reads the eight descriptor words in order from chain pointer + 0, +4 and so on up to +28. Each request holds its address and direction until mem_rdy completes it.
- R4: A fetched descriptor with word-0 bit 31 clear sets the halted status bit (bit 0). It starts no mover transfer and performs no write-back.
- R5: A valid descriptor gives the mover one single-cycle mv_start. At that point mv_bytes equals word-1 bits 21:0, mv_src equals word 2, and mv_dst equals word 4.
- R6: Word-0 bits 1:0 select what is written to the status pointer after the transfer. The codes are: 0 writes nothing; 1 writes the status word; 2 writes word 0 with bit 31 cleared; 3 writes the remaining byte count.
- R7: If word-0 bit 2 is set, word 0 with bit 31 cleared is written back to the descriptor's own first word. This happens after the status write.
- R8: Every finished descriptor sets interrupt-pending bit 0 (reg_addr 4), whatever word-0 bit 8 holds. irq_o is the pending bit gated by bit 8 of that descriptor. Writing 1 to bit 0 clears the pending bit.
- R9: The next descriptor address is word-7 bits 26:0 shifted left by 5. Word-7 bit 27 and the bits above it have no effect on the address.
- R10: A doorbell written while the channel is busy is kept. If the chain then halts on an invalid descriptor, that same descriptor is fetched again at once, with no further write.
- R11: The byte-count register (reg_addr 6) holds the remaining count that the mover reports with mv_done.
- R12: With config bit 0 (reg_addr 0) clear, no descriptor fetch starts. A doorbell stays pending until the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 config, 1 chain pointer, 2 status pointer, 3 doorbell, 4 interrupt, 5 status, 6 byte count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt line: pending flag gated by the descriptor's enable bit |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Completes the current memory request |
| mv_start | output | 1 | One-cycle start pulse to the data mover |
| mv_src | output | 32 | Source address for the mover |
| mv_dst | output | 32 | Destination address for the mover |
| mv_bytes | output | BC_W | Byte count for the mover |
| mv_done | input | 1 | Mover has finished |
| mv_resid | input | BC_W | Remaining byte count, valid with mv_done |

## Verification
The doorbell is the one stimulus with a fixed latency, so it is the only one checked cycle by cycle. Status bit 2 is sampled at the falling edge after the write edge. The fetch request and the cleared doorbell bit are sampled one falling edge after that. All other results depend on the latency of the memory model and of the mover. For those, the bench waits on port events: a mover start, or a halted status with no doorbell pending. The memory and mover models log every request address, every write and every start. The checks then compare these logs, and the register read-back, with values worked out from the descriptor words.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_TRANSFER, S_WRITEBACK, S_NEXT
  } seq_state_e;

  // register select codes
  localparam logic [2:0] RA_CFG    = 3'd0;
  localparam logic [2:0] RA_CHAIN  = 3'd1;
  localparam logic [2:0] RA_STPTR  = 3'd2;
  localparam logic [2:0] RA_BELL   = 3'd3;
  localparam logic [2:0] RA_IRQ    = 3'd4;
  localparam logic [2:0] RA_STATUS = 3'd5;
  localparam logic [2:0] RA_COUNT  = 3'd6;

  // word-0 control bit positions
  localparam int W0_VALID = 31;
  localparam int W0_IE    = 8;
  localparam int W0_CLRV  = 2;

  // word indices within a descriptor
  localparam int WI_CTRL = 0;
  localparam int WI_CNT  = 1;
  localparam int WI_SRC  = 2;
  localparam int WI_DST  = 4;
  localparam int WI_LINK = 7;

  function automatic logic [31:0] link_to_addr(input logic [31:0] link);
    return {link[26:0], 5'b0};
  endfunction

  function automatic logic [31:0] drop_valid(input logic [31:0] w0);
    logic [31:0] r;
    r = w0;
    r[W0_VALID] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] status_word(input logic bell, input logic vld,
                                              input logic halt);
    return {29'b0, bell, vld, halt};
  endfunction

  function automatic logic [31:0] wb_value(input logic [1:0] sel, input logic [31:0] stat,
                                           input logic [31:0] w0, input logic [31:0] cnt);
    case (sel)
      2'd1:    return stat;
      2'd2:    return drop_valid(w0);
      2'd3:    return cnt;
      default: return 32'b0;
    endcase
  endfunction

endpackage

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
  import dmaseq_pkg::*;
#(
  parameter int BC_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            ev_fetch_start,
  input  logic            ev_halt,
  input  logic            ev_check_ok,
  input  logic            ev_xfer_done,
  input  logic            ev_desc_done,
  input  logic            desc_ie,
  input  logic [31:0]     next_addr,
  input  logic [BC_W-1:0] mv_resid,
  output logic            cfg_en,
  output logic            bell_pend,
  output logic [31:0]     chain_ptr,
  output logic [31:0]     stat_ptr,
  output logic [31:0]     status_w,
  output logic [BC_W-1:0] count_q,
  output logic            irq_pend,
  output logic            halted,
  output logic            irq_o
);
  logic [31:0] cfg_q;
  logic        bell_flag, vld_flag, irq_ie;

  wire wr_bell = reg_we && reg_addr == RA_BELL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; chain_ptr <= '0; stat_ptr <= '0;
      bell_pend <= 1'b0; bell_flag <= 1'b0; vld_flag <= 1'b0;
      halted <= 1'b0; irq_pend <= 1'b0; irq_ie <= 1'b0; count_q <= '0;
    end else begin
      if (reg_we && reg_addr == RA_CFG)   cfg_q <= reg_wdata;
      if (reg_we && reg_addr == RA_STPTR) stat_ptr <= {reg_wdata[31:2], 2'b0};
      if (ev_desc_done)                   chain_ptr <= next_addr;
      else if (reg_we && reg_addr == RA_CHAIN) chain_ptr <= {reg_wdata[31:5], 5'b0};
      if (ev_fetch_start) begin
        bell_pend <= 1'b0; bell_flag <= 1'b0; halted <= 1'b0;
      end
      if (wr_bell) begin
        bell_pend <= 1'b1; bell_flag <= 1'b1;
      end
      if (ev_halt)      begin halted <= 1'b1; vld_flag <= 1'b0; end
      if (ev_check_ok)  vld_flag <= 1'b1;
      if (ev_xfer_done) count_q <= mv_resid;
      if (reg_we && reg_addr == RA_IRQ && reg_wdata[0]) irq_pend <= 1'b0;
      if (ev_desc_done) begin
        irq_pend <= 1'b1; irq_ie <= desc_ie; vld_flag <= 1'b0;
      end
    end
  end

  assign cfg_en   = cfg_q[0];
  assign status_w = status_word(bell_flag, vld_flag, halted);
  assign irq_o    = irq_pend && irq_ie;

  always_comb begin
    case (reg_addr)
      RA_CFG:    reg_rdata = cfg_q;
      RA_CHAIN:  reg_rdata = chain_ptr;
      RA_STPTR:  reg_rdata = stat_ptr;
      RA_IRQ:    reg_rdata = {31'b0, irq_pend};
      RA_STATUS: reg_rdata = status_w;
      RA_COUNT:  reg_rdata = {{(32-BC_W){1'b0}}, count_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmaseq_seq.sv
module dmaseq_seq
  import dmaseq_pkg::*;
#(
  parameter int BC_W       = 22,
  parameter int DESC_WORDS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            bell_pend,
  input  logic [31:0]     chain_ptr,
  input  logic [31:0]     stat_ptr,
  input  logic [31:0]     status_w,
  input  logic [BC_W-1:0] count_q,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_rdy,
  input  logic            mv_done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  output logic            mv_start,
  output logic [31:0]     mv_src,
  output logic [31:0]     mv_dst,
  output logic [BC_W-1:0] mv_bytes,
  output logic            ev_fetch_start,
  output logic            ev_halt,
  output logic            ev_check_ok,
  output logic            ev_xfer_done,
  output logic            ev_desc_done,
  output logic            desc_ie,
  output logic [31:0]     next_addr
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  seq_state_e       state;
  logic [IDX_W-1:0] widx;
  logic [31:0]      w0;
  logic             wb_step;

  wire word_ok = mem_req && mem_rdy;
  wire step_st = state == S_WRITEBACK && !wb_step && w0[1:0] != 2'd0;
  wire step_cv = state == S_WRITEBACK && wb_step && w0[W0_CLRV];

  assign ev_fetch_start = state == S_IDLE && bell_pend && cfg_en;
  assign ev_halt        = state == S_CHECK && !w0[W0_VALID];
  assign ev_check_ok    = state == S_CHECK && w0[W0_VALID];
  assign ev_xfer_done   = state == S_TRANSFER && mv_done;
  assign ev_desc_done   = state == S_NEXT;
  assign desc_ie        = w0[W0_IE];

  assign mem_req = state == S_FETCH || step_st || step_cv;
  assign mem_we  = state == S_WRITEBACK;
  always_comb begin
    mem_addr  = chain_ptr + {{(30-IDX_W){1'b0}}, widx, 2'b00};
    mem_wdata = '0;
    if (step_st) begin
      mem_addr  = stat_ptr;
      mem_wdata = wb_value(w0[1:0], status_w, w0, {{(32-BC_W){1'b0}}, count_q});
    end else if (step_cv) begin
      mem_addr  = chain_ptr;
      mem_wdata = drop_valid(w0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; widx <= '0; w0 <= '0; wb_step <= 1'b0;
      mv_start <= 1'b0; mv_src <= '0; mv_dst <= '0; mv_bytes <= '0; next_addr <= '0;
    end else begin
      mv_start <= ev_check_ok;
      case (state)
        S_IDLE: if (ev_fetch_start) begin state <= S_FETCH; widx <= '0; end
        S_FETCH: if (word_ok) begin
          case (int'(widx))
            WI_CTRL: w0 <= mem_rdata;
            WI_CNT:  mv_bytes <= mem_rdata[BC_W-1:0];
            WI_SRC:  mv_src <= mem_rdata;
            WI_DST:  mv_dst <= mem_rdata;
            WI_LINK: next_addr <= link_to_addr(mem_rdata);
            default: ;
          endcase
          widx <= widx + 1'b1;
          if (widx == LAST_IDX) state <= S_CHECK;
        end
        S_CHECK: state <= w0[W0_VALID] ? S_TRANSFER : S_IDLE;
        S_TRANSFER: if (mv_done) begin state <= S_WRITEBACK; wb_step <= 1'b0; end
        S_WRITEBACK:
          if (!wb_step) begin
            if (!step_st || mem_rdy) wb_step <= 1'b1;
          end else if (!step_cv || mem_rdy) state <= S_NEXT;
        S_NEXT: begin
          widx  <= '0;
          state <= cfg_en ? S_FETCH : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaseq_channel.sv
module dmaseq_channel
  import dmaseq_pkg::*;
#(
  parameter int BC_W       = 22,
  parameter int DESC_WORDS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq_o,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_rdy,
  output logic            mv_start,
  output logic [31:0]     mv_src,
  output logic [31:0]     mv_dst,
  output logic [BC_W-1:0] mv_bytes,
  input  logic            mv_done,
  input  logic [BC_W-1:0] mv_resid
);
  logic            cfg_en, bell_pend, irq_pend, halted, desc_ie;
  logic            ev_fetch_start, ev_halt, ev_check_ok, ev_xfer_done, ev_desc_done;
  logic [31:0]     chain_ptr, stat_ptr, status_w, next_addr;
  logic [BC_W-1:0] count_q;

  dmaseq_regs #(.BC_W(BC_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .ev_fetch_start, .ev_halt, .ev_check_ok, .ev_xfer_done, .ev_desc_done,
    .desc_ie, .next_addr, .mv_resid, .cfg_en, .bell_pend, .chain_ptr, .stat_ptr,
    .status_w, .count_q, .irq_pend, .halted, .irq_o
  );

  dmaseq_seq #(.BC_W(BC_W), .DESC_WORDS(DESC_WORDS)) u_seq (
    .clk, .rst_n, .cfg_en, .bell_pend, .chain_ptr, .stat_ptr, .status_w, .count_q,
    .mem_rdata, .mem_rdy, .mv_done, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mv_start, .mv_src, .mv_dst, .mv_bytes, .ev_fetch_start, .ev_halt, .ev_check_ok,
    .ev_xfer_done, .ev_desc_done, .desc_ie, .next_addr
  );
endmodule

// File: rtl/dmaseq_checker.sv
module dmaseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_rdy,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mv_start,
  input logic        ev_fetch_start,
  input logic        ev_desc_done,
  input logic        irq_pend,
  input logic        halted
);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_done |=> irq_pend);

  assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  assert_fetch_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_start |=> mem_req && !mem_we);
endmodule

bind dmaseq_channel dmaseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we),
  .mem_addr(mem_addr), .mv_start(mv_start), .ev_fetch_start(ev_fetch_start),
  .ev_desc_done(ev_desc_done), .irq_pend(irq_pend), .halted(halted)
);

// File: tb/dmaseq_channel_bench.sv
module dmaseq_channel_bench;
  localparam int BC_W = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_o, mem_req, mem_we, mem_rdy = 1'b0, mv_start, mv_done = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, mv_src, mv_dst;
  logic [BC_W-1:0] mv_bytes, mv_resid = '0;

  int checks = 0, fails = 0;
  logic [31:0] mem [64];
  logic [31:0] rd_log [32];
  logic [31:0] wa_log [16], wd_log [16];
  int rd_n = 0, wr_n = 0, st_n = 0, mv_cnt = 0;
  logic [31:0] cap_src, cap_dst;
  logic [BC_W-1:0] cap_bytes;

  always #5 clk = ~clk;

  dmaseq_channel #(.BC_W(BC_W)) u_dmaseq_channel (.*);

  assign mem_rdata = mem[mem_addr[7:2]];

  // memory model: every request completes on the second cycle
  always @(posedge clk) begin
    mem_rdy <= mem_req && !mem_rdy;
    if (mem_req && mem_rdy) begin
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wa_log[wr_n % 16] <= mem_addr; wd_log[wr_n % 16] <= mem_wdata;
        wr_n <= wr_n + 1;
      end else begin
        rd_log[rd_n % 32] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  // mover model: done three cycles after start
  always @(posedge clk) begin
    mv_done <= 1'b0;
    if (mv_start) begin
      cap_src <= mv_src; cap_dst <= mv_dst; cap_bytes <= mv_bytes;
      st_n <= st_n + 1; mv_cnt <= 3;
    end else if (mv_cnt != 0) begin
      mv_cnt <= mv_cnt - 1;
      if (mv_cnt == 1) mv_done <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_desc(input int base, input logic [31:0] c0, input logic [31:0] c1,
                          input logic [31:0] s, input logic [31:0] d, input logic [31:0] lk);
    for (int i = 0; i < 8; i++) mem[base/4 + i] = 32'hDEAD_0000 + 32'(i);
    mem[base/4] = c0; mem[base/4+1] = c1; mem[base/4+2] = s;
    mem[base/4+4] = d; mem[base/4+7] = lk;
  endtask

  // wait until halted with no doorbell pending
  task automatic wait_rest();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); rd(3'd5, s);
      if (s[0] && !s[2]) return;
    end
    chk("wait for halt", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(3'd5, s);
    chk("R1 status", s, 32'h0);
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk("R1 mv_start", {31'b0, mv_start}, 32'h0);
  endtask

  task automatic t_disabled_then_invalid();
    logic [31:0] s;
    wr(3'd1, 32'h60);
    wr(3'd2, 32'hC0);
    wr(3'd3, 32'h1234_5678);
    repeat (20) @(negedge clk);
    chk("R12 no fetch while disabled", 32'(rd_n), 32'd0);
    rd(3'd5, s);
    chk("R12 doorbell still pending", 32'(s[2]), 32'd1);
    wr(3'd0, 32'h1);
    wait_rest();
    rd(3'd5, s);
    chk("R4 halted bit", s, 32'h1);
    chk("R4 no mover start", 32'(st_n), 32'd0);
    chk("R4 no write-back", 32'(wr_n), 32'd0);
    chk("R3 eight reads", 32'(rd_n), 32'd8);
  endtask

  task automatic t_single();
    logic [31:0] s;
    bit ok;
    wr(3'd4, 32'h1);
    mv_resid = 22'd5;
    wr(3'd1, 32'h00);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0;
    @(negedge clk); reg_we = 1'b0;
    rd(3'd5, s);
    chk("R2 bell bit next cycle", 32'(s[2]), 32'd1);
    chk("R2 no request yet", {31'b0, mem_req}, 32'd0);
    @(negedge clk); rd(3'd5, s);
    chk("R2 fetch one cycle later", {31'b0, mem_req}, 32'd1);
    chk("R2 bell bit cleared at fetch", 32'(s[2]), 32'd0);
    wait_rest();
    ok = 1;
    for (int i = 0; i < 8; i++) if (rd_log[8 + i] !== 32'(4 * i)) ok = 0;
    chk("R3 fetch order", 32'(ok), 32'd1);
    chk("R5 bytes", 32'(cap_bytes), 32'h40);
    chk("R5 src", cap_src, 32'h1000);
    chk("R5 dst", cap_dst, 32'h2000);
    chk("R6 code1 writes", 32'(wr_n), 32'd1);
    chk("R6 code1 addr", wa_log[0], 32'hC0);
    chk("R6 code1 status data", wd_log[0], 32'h2);
    rd(3'd4, s);
    chk("R8 pending without enable", s, 32'h1);
    chk("R8 line gated off", {31'b0, irq_o}, 32'd0);
    rd(3'd6, s);
    chk("R11 byte count", s, 32'd5);
    chk("R9 link followed", 32'(rd_n), 32'd24);
  endtask

  task automatic t_irq_clear();
    logic [31:0] s;
    wr(3'd4, 32'h0);
    rd(3'd4, s);
    chk("R8 write 0 keeps pending", s, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, s);
    chk("R8 write 1 clears", s, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] s;
    int r0, w0n;
    r0 = rd_n; w0n = wr_n;
    mv_resid = 22'd7;
    wr(3'd1, 32'h20);
    wr(3'd3, 32'h0);
    wait_rest();
    chk("R5 max byte count", 32'(cap_bytes), 32'h3F_FFFF);
    chk("R9 bit27 ignored", cap_src, 32'h5000);
    chk("R6/R7 write count", 32'(wr_n - w0n), 32'd3);
    chk("R6 code2 addr", wa_log[w0n % 16], 32'hC0);
    chk("R6 code2 data", wd_log[w0n % 16], 32'h0000_0106);
    chk("R7 clear-valid addr", wa_log[(w0n + 1) % 16], 32'h20);
    chk("R7 clear-valid data", mem[8], 32'h0000_0106);
    chk("R6 code3 remaining", wd_log[(w0n + 2) % 16], 32'd7);
    chk("R8 line with enable", {31'b0, irq_o}, 32'd1);
    rd(3'd1, s);
    chk("R9 final pointer", s, 32'h60);
    chk("R3 reads in chain", 32'(rd_n - r0), 32'd24);
  endtask

  task automatic t_busy_bell();
    int r0, w0n, s0;
    r0 = rd_n; w0n = wr_n; s0 = st_n;
    put_desc(0, 32'h8000_0000, 32'h10, 32'h7000, 32'h8000, 32'h3);
    wr(3'd4, 32'h1);
    wr(3'd1, 32'h00);
    wr(3'd3, 32'h0);
    for (int i = 0; i < 200 && st_n == s0; i++) @(negedge clk);
    wr(3'd3, 32'h0);
    wait_rest();
    chk("R10 refetch of halted descriptor", 32'(rd_n - r0), 32'd24);
    chk("R10 same address", rd_log[(r0 + 16) % 32], 32'h60);
    chk("R6 code0 writes nothing", 32'(wr_n - w0n), 32'd0);
  endtask

  initial begin
    put_desc(32'h00, 32'h8000_0001, 32'hF0C0_0040, 32'h1000, 32'h2000, 32'h3);
    put_desc(32'h20, 32'h8000_0106, 32'h100, 32'h3000, 32'h4000, 32'h0800_0002);
    put_desc(32'h40, 32'h8000_0103, 32'h003F_FFFF, 32'h5000, 32'h6000, 32'h3);
    put_desc(32'h60, 32'h0000_0103, 32'h20, 32'h9000, 32'hA000, 32'h0);
    for (int i = 32; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_then_invalid();
    t_single();
    t_irq_clear();
    t_chain();
    t_busy_bell();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule